// File: doc/BRIEF.md
# Serial Link Power-Down Handshake Controller

This block sits next to a UART and agrees with the far end of the serial link on when the link may drop into a low-power "interface down" state. It has two independent state machines, one for the transmit direction and one for the receive direction. Each state machine moves between three states: up, pending down and down. The current state of each is reported to a power manager.

The transmit side watches local transmit activity. After a programmable number of idle cycles it releases its active-low request output. It then waits a bounded number of cycles for the peer's active-low confirm input to be released. If the confirm arrives in time, the transmit side enters down. If it does not, the transmit side returns to up and reports a timeout.

The receive side follows the peer's request line. It confirms only once the local receiver has drained. While the link is up, the confirm pins carry ordinary RTS/CTS flow control. All inputs from the peer pass through a synchronizer before any state machine uses them.

Top module: `lpd_handshake`

## Requirements
- R1: During and immediately after reset, both `tx_state` and `rx_state` read up (encoding: 0 = up, 1 = pending down, 2 = down). At the same time `req_out_n` is 0 and `tx_timeout` is 0.
- R2: In transmit up, once `tx_active` has been low at `cfg_idle` consecutive clock edges, `tx_state` becomes pending and `req_out_n` becomes 1. A value of 0 in `cfg_idle` acts as 1.
- R3: `tx_active` high at any edge during the idle count restarts the count from zero.
- R4: In transmit pending, a high level on `cfm_in_n` reaches the state machine after SYNC_STAGES edges (default 2). The transmit side enters down on the following edge.
- R5: The transmit side may stay in pending for at most `cfg_wait` edges without the synchronized confirm going high (a value of 0 acts as 1). At that edge it returns to up, `req_out_n` goes back to 0, and `tx_timeout` is 1 for exactly one cycle.
- R6: `tx_active` high in transmit pending or down returns the transmit side to up on the next edge, with `req_out_n` 0.
- R7: A falling edge of the synchronized `req_in_n` returns the transmit side from pending or down to up, on the edge after the falling level has passed the synchronizer.
- R8: In receive up, a synchronized high `req_in_n` moves the receive side to pending. The receive side stays in pending while `rx_active` is high, and enters down on the first edge where `rx_active` is low.
- R9: A synchronized low `req_in_n` returns the receive side from pending or down to up on the next edge.
- R10: `cfm_out_n` equals `uart_rts_n` in receive up, is 0 in receive pending, and is 1 in receive down. `uart_cts_n` equals the synchronized `cfm_in_n` in transmit up and is 1 otherwise.
- R11: The two sides are independent. The receive side can reach down while the transmit side stays up, and the reverse also holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_idle | input | CW | Transmit idle cycles before the request is released |
| cfg_wait | input | CW | Maximum cycles spent waiting for the peer confirm |
| tx_active | input | 1 | Local transmitter busy or holding data |
| rx_active | input | 1 | Local receiver still draining |
| uart_rts_n | input | 1 | RTS flow-control output of the UART |
| uart_cts_n | output | 1 | CTS flow-control input to the UART |
| req_out_n | output | 1 | Active-low link request to the peer |
| req_in_n | input | 1 | Active-low link request from the peer |
| cfm_out_n | output | 1 | Confirm to the peer, shared with RTS |
| cfm_in_n | input | 1 | Confirm from the peer, shared with CTS |
| tx_state | output | 2 | Transmit-side state |
| rx_state | output | 2 | Receive-side state |
| tx_timeout | output | 1 | One-cycle pulse when the confirm wait expires |

## Verification
Both state machines drive their outputs directly from their state registers. A wrong state therefore shows up on `tx_state`, `rx_state`, `req_out_n` or `cfm_out_n` in the same cycle it is entered. An off-by-one in the idle or wait counter shifts the pending entry or the timeout pulse by exactly one sampled cycle. The bench sweeps `cfg_idle` and `cfg_wait` over small values and samples at the exact cycle it computes, so such a shift is caught. A synchronizer that is too short or too long moves every peer-driven transition by whole cycles, and the checks taken one cycle before and at the expected edge detect this.

// File: rtl/lpd_pkg.sv
package lpd_pkg;
   typedef enum logic [1:0] {
      LPD_UP   = 2'd0,
      LPD_PEND = 2'd1,
      LPD_DOWN = 2'd2
   } lpd_state_e;
endpackage

// File: rtl/lpd_sync.sv
module lpd_sync #(
   parameter int               STAGES = 2,
   parameter int               WIDTH  = 1,
   parameter logic [WIDTH-1:0] INIT   = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] pipe;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[0] <= INIT;
            else        pipe[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[g] <= INIT;
            else        pipe[g] <= pipe[g-1];
         end
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/lpd_tx_fsm.sv
module lpd_tx_fsm
   import lpd_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] idle_lim,
   input  logic [CW-1:0] wait_lim,
   input  logic          tx_active,
   input  logic          peer_wake,
   input  logic          cfm_high,
   output lpd_state_e    state,
   output logic          timeout
);
   localparam int CWX = CW + 1;

   lpd_state_e    nxt;
   logic [CW-1:0] cnt, cnt_nxt;
   logic [CW:0]   cnt_inc;
   logic          to_nxt;
   logic          idle_done, wait_done;

   assign cnt_inc   = CWX'(cnt) + CWX'(1);
   assign idle_done = cnt_inc >= CWX'(idle_lim);
   assign wait_done = cnt_inc >= CWX'(wait_lim);

   always_comb begin
      nxt     = state;
      cnt_nxt = cnt;
      to_nxt  = 1'b0;
      case (state)
         LPD_UP: begin
            if (tx_active) begin
               cnt_nxt = '0;
            end else if (idle_done) begin
               nxt     = LPD_PEND;
               cnt_nxt = '0;
            end else begin
               cnt_nxt = cnt_inc[CW-1:0];
            end
         end
         LPD_PEND: begin
            if (tx_active || peer_wake) begin
               nxt     = LPD_UP;
               cnt_nxt = '0;
            end else if (cfm_high) begin
               nxt     = LPD_DOWN;
               cnt_nxt = '0;
            end else if (wait_done) begin
               nxt     = LPD_UP;
               cnt_nxt = '0;
               to_nxt  = 1'b1;
            end else begin
               cnt_nxt = cnt_inc[CW-1:0];
            end
         end
         LPD_DOWN: begin
            if (tx_active || peer_wake) begin
               nxt     = LPD_UP;
               cnt_nxt = '0;
            end
         end
         default: begin
            nxt     = LPD_UP;
            cnt_nxt = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= LPD_UP;
         cnt     <= '0;
         timeout <= 1'b0;
      end else begin
         state   <= nxt;
         cnt     <= cnt_nxt;
         timeout <= to_nxt;
      end
   end

   // R2
   idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == LPD_PEND && $past(state) == LPD_UP) |-> !$past(tx_active));
   // R4
   no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == LPD_DOWN && $past(state) != LPD_DOWN) |-> $past(state) == LPD_PEND);
   // R5
   timeout_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |=> !timeout);
   // R5
   timeout_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |-> (state == LPD_UP && $past(state) == LPD_PEND));
   // R6
   tx_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state != LPD_UP && tx_active) |=> state == LPD_UP);
endmodule

// File: rtl/lpd_rx_fsm.sv
module lpd_rx_fsm
   import lpd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       peer_req_high,
   input  logic       rx_active,
   output lpd_state_e state
);
   lpd_state_e nxt;

   always_comb begin
      nxt = state;
      case (state)
         LPD_UP:   if (peer_req_high) nxt = LPD_PEND;
         LPD_PEND: begin
            if (!peer_req_high)  nxt = LPD_UP;
            else if (!rx_active) nxt = LPD_DOWN;
         end
         LPD_DOWN: if (!peer_req_high) nxt = LPD_UP;
         default:  nxt = LPD_UP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= LPD_UP;
      else        state <= nxt;
   end

   // R8
   rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == LPD_PEND && rx_active && peer_req_high) |=> state == LPD_PEND);
   // R9
   rx_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state != LPD_UP && !peer_req_high) |=> state == LPD_UP);
endmodule

// File: rtl/lpd_handshake.sv
module lpd_handshake
   import lpd_pkg::*;
#(
   parameter int CW           = 16,
   parameter int SYNC_STAGES  = 2,
   parameter bit HOLD_CFM_PND = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] cfg_idle,
   input  logic [CW-1:0] cfg_wait,
   input  logic          tx_active,
   input  logic          rx_active,
   input  logic          uart_rts_n,
   output logic          uart_cts_n,
   output logic          req_out_n,
   input  logic          req_in_n,
   output logic          cfm_out_n,
   input  logic          cfm_in_n,
   output logic [1:0]    tx_state,
   output logic [1:0]    rx_state,
   output logic          tx_timeout
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("lpd_handshake: SYNC_STAGES must be at least 2");
   end
   if (CW < 2) begin : g_bad_cw
      $error("lpd_handshake: CW must be at least 2");
   end

   logic [1:0] peer_raw, peer_s;
   logic       req_in_s, cfm_in_s, req_prev, peer_fall;
   lpd_state_e tx_st, rx_st;

   assign peer_raw = {req_in_n, cfm_in_n};

   lpd_sync #(.STAGES(SYNC_STAGES), .WIDTH(2), .INIT(2'b00)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (peer_raw),
      .q    (peer_s)
   );

   assign req_in_s = peer_s[1];
   assign cfm_in_s = peer_s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_prev <= 1'b0;
      else        req_prev <= req_in_s;
   end
   assign peer_fall = req_prev & ~req_in_s;

   lpd_tx_fsm #(.CW(CW)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .idle_lim (cfg_idle),
      .wait_lim (cfg_wait),
      .tx_active(tx_active),
      .peer_wake(peer_fall),
      .cfm_high (cfm_in_s),
      .state    (tx_st),
      .timeout  (tx_timeout)
   );

   lpd_rx_fsm u_rx (
      .clk          (clk),
      .rst_n        (rst_n),
      .peer_req_high(req_in_s),
      .rx_active    (rx_active),
      .state        (rx_st)
   );

   assign tx_state   = tx_st;
   assign rx_state   = rx_st;
   assign req_out_n  = (tx_st != LPD_UP);
   assign uart_cts_n = (tx_st == LPD_UP) ? cfm_in_s : 1'b1;

   if (HOLD_CFM_PND) begin : g_cfm_hold
      always_comb begin
         case (rx_st)
            LPD_UP:   cfm_out_n = uart_rts_n;
            LPD_PEND: cfm_out_n = 1'b0;
            default:  cfm_out_n = 1'b1;
         endcase
      end
   end else begin : g_cfm_pass
      assign cfm_out_n = (rx_st == LPD_DOWN) ? 1'b1 : uart_rts_n;
   end

   // R10
   cts_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_state != 2'd0) |-> uart_cts_n);
   // R10
   cfm_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_state == 2'd2) |-> cfm_out_n);
   // R7
   peer_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_state != 2'd0 && peer_fall) |=> tx_state == 2'd0);
endmodule

// File: tb/sim_lpd_handshake.sv
module sim_lpd_handshake;
   localparam int CW   = 16;
   localparam int SYNC = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CW-1:0] cfg_idle, cfg_wait;
   logic          tx_active, rx_active, uart_rts_n, req_in_n, cfm_in_n;
   logic          uart_cts_n, req_out_n, cfm_out_n, tx_timeout;
   logic [1:0]    tx_state, rx_state;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   lpd_handshake #(.CW(CW), .SYNC_STAGES(SYNC)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_idle(cfg_idle), .cfg_wait(cfg_wait),
      .tx_active(tx_active), .rx_active(rx_active), .uart_rts_n(uart_rts_n),
      .uart_cts_n(uart_cts_n), .req_out_n(req_out_n), .req_in_n(req_in_n),
      .cfm_out_n(cfm_out_n), .cfm_in_n(cfm_in_n), .tx_state(tx_state),
      .rx_state(rx_state), .tx_timeout(tx_timeout)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic eq(input string req, input int act, input int exp);
      chk(act == exp, req, act, exp);
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      cfg_idle = 16'd4; cfg_wait = 16'd8;
      tx_active = 1'b1; rx_active = 1'b1; uart_rts_n = 1'b0;
      req_in_n = 1'b0; cfm_in_n = 1'b0;
      step(3);
      // R1 during reset
      eq("R1 tx_state", int'(tx_state), 0);
      eq("R1 req_out_n", int'(req_out_n), 0);
      rst_n = 1'b1;
      step(1);
      // R1 after reset
      eq("R1 tx_state", int'(tx_state), 0);
      eq("R1 rx_state", int'(rx_state), 0);
      eq("R1 tx_timeout", int'(tx_timeout), 0);

      // R2 sweep of idle length, R6 return from pending
      for (int n = 0; n <= 6; n++) begin
         int eff;
         eff = (n == 0) ? 1 : n;
         cfg_idle = CW'(n);
         tx_active = 1'b1;
         step(1);
         tx_active = 1'b0;
         if (eff > 1) begin
            step(eff - 1);
            eq("R2 still up", int'(tx_state), 0);
         end
         step(1);
         eq("R2 pending", int'(tx_state), 1);
         eq("R2 req_out_n", int'(req_out_n), 1);
         tx_active = 1'b1;
         step(1);
         eq("R6 up from pending", int'(tx_state), 0);
         eq("R6 req_out_n", int'(req_out_n), 0);
      end

      // R3 restart of idle count
      cfg_idle = 16'd4;
      tx_active = 1'b0; step(3);
      tx_active = 1'b1; step(1);
      tx_active = 1'b0; step(3);
      eq("R3 restarted", int'(tx_state), 0);
      step(1);
      eq("R3 pending", int'(tx_state), 1);
      tx_active = 1'b1; step(1);

      // R4 confirm, R10 CTS gating, R11 rx stays up
      cfg_idle = 16'd1; cfg_wait = 16'd8;
      tx_active = 1'b0; step(1);
      eq("R4 pending", int'(tx_state), 1);
      eq("R10 cts blocked", int'(uart_cts_n), 1);
      cfm_in_n = 1'b1;
      step(SYNC);
      eq("R4 not yet down", int'(tx_state), 1);
      step(1);
      eq("R4 down", int'(tx_state), 2);
      eq("R11 rx up", int'(rx_state), 0);
      tx_active = 1'b1; step(1);
      eq("R6 up from down", int'(tx_state), 0);
      eq("R6 req_out_n", int'(req_out_n), 0);
      eq("R10 cts pass high", int'(uart_cts_n), 1);
      cfm_in_n = 1'b0;
      step(SYNC - 1);
      eq("R10 cts lag", int'(uart_cts_n), 1);
      step(1);
      eq("R10 cts pass low", int'(uart_cts_n), 0);

      // R5 sweep of wait length
      cfg_idle = 16'd1;
      for (int w = 0; w <= 8; w++) begin
         int eff;
         eff = (w == 0) ? 1 : w;
         cfg_wait = CW'(w);
         tx_active = 1'b1; step(1);
         tx_active = 1'b0; step(1);
         eq("R5 pending", int'(tx_state), 1);
         if (eff > 1) begin
            step(eff - 1);
            eq("R5 still pending", int'(tx_state), 1);
            eq("R5 no pulse yet", int'(tx_timeout), 0);
         end
         step(1);
         eq("R5 back up", int'(tx_state), 0);
         eq("R5 pulse", int'(tx_timeout), 1);
         eq("R5 req_out_n", int'(req_out_n), 0);
         tx_active = 1'b1; step(1);
         eq("R5 pulse ends", int'(tx_timeout), 0);
      end

      // R7 peer request wakes transmit side, R9 from down
      cfg_wait = 16'd8;
      req_in_n = 1'b1; rx_active = 1'b0;
      step(SYNC + 2);
      eq("R8 rx down", int'(rx_state), 2);
      tx_active = 1'b0; step(1);
      cfm_in_n = 1'b1; step(SYNC + 1);
      eq("R7 tx down", int'(tx_state), 2);
      cfg_idle = 16'd20;
      req_in_n = 1'b0;
      step(SYNC);
      eq("R7 not yet", int'(tx_state), 2);
      step(1);
      eq("R7 tx up", int'(tx_state), 0);
      eq("R9 rx up from down", int'(rx_state), 0);
      cfm_in_n = 1'b0;

      // R10 RTS passthrough, R8 hold and drain, R11
      tx_active = 1'b1;
      uart_rts_n = 1'b1; #1;
      eq("R10 rts high", int'(cfm_out_n), 1);
      uart_rts_n = 1'b0; #1;
      eq("R10 rts low", int'(cfm_out_n), 0);
      step(1);
      uart_rts_n = 1'b1;
      rx_active = 1'b1; req_in_n = 1'b1;
      step(SYNC);
      eq("R8 rx still up", int'(rx_state), 0);
      step(1);
      eq("R8 rx pending", int'(rx_state), 1);
      eq("R10 cfm held", int'(cfm_out_n), 0);
      step(2);
      eq("R8 hold while active", int'(rx_state), 1);
      rx_active = 1'b0; step(1);
      eq("R8 rx down", int'(rx_state), 2);
      eq("R10 cfm released", int'(cfm_out_n), 1);
      eq("R11 tx up", int'(tx_state), 0);
      eq("R11 req_out_n", int'(req_out_n), 0);

      // R9 from pending
      req_in_n = 1'b0; step(SYNC + 1);
      eq("R9 rx up", int'(rx_state), 0);
      rx_active = 1'b1; req_in_n = 1'b1; step(SYNC + 1);
      eq("R9 rx pending", int'(rx_state), 1);
      req_in_n = 1'b0; step(SYNC + 1);
      eq("R9 rx up from pending", int'(rx_state), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule